// File: doc/BRIEF.md
# Serial-Bus Control Register Slave

This block is a slave on a two-wire serial bus (I2C style). It owns a small bank of 8-bit control registers whose bits drive enables and mode selects for the clock outputs of a synthesizer. A fast system clock samples SCL and SDA through two-flop synchronizers. The block finds start and stop conditions and matches a fixed 7-bit device address. It acknowledges every accepted byte by pulling SDA low for one bit time.

A write transfer has three parts. After the address, the master must send two placeholder bytes, a command code and then a byte count. The slave acknowledges both and ignores their contents. Every byte after that lands in the registers in order, starting at register 0 and going up until the stop. A read transfer has no placeholder bytes. Right after the address acknowledge, the slave shifts out register 0, then register 1, and so on, until the master answers with a not-acknowledge.

The registers load their defaults only on reset, so a system that never touches the bus runs on those defaults. SDA is open-drain. The block only asserts a drive-low request, and the pad logic outside the block combines it with the bus.

Top module: `ctlbus_regslave`

## Requirements
- R1: While reset is high and right after it, `regs_o` equals `REG_INIT` and `sda_drive_low` is 0. Register k occupies bits [8k+7:8k] of `regs_o`.
- R2: A start is SDA falling while SCL is high, and it begins a new transfer at any time, including a repeated start. A stop is SDA rising while SCL is high. After a stop, the slave releases SDA and ignores bus clocks until the next start.
- R3: The first byte after a start is 7 address bits, MSB first, then the R/W bit. When the address equals `DEV_ADDR` (default 7'b1101001, so 0xD2 for a write and 0xD3 for a read), the slave drives SDA low during the ninth clock.
- R4: On an address mismatch the slave gives no acknowledge for either R/W value. It then leaves SDA released and changes no register until the next start.
- R5: In a write, the two bytes after the address are acknowledged and change no register. Each byte after them is acknowledged and stored in register 0, 1, 2, and so on, in order.
- R6: In a write, data bytes beyond register `NUM_REGS`-1 are acknowledged and discarded.
- R7: In a read, the slave sends register 0, 1, 2 and onward, MSB first, starting right after the address acknowledge. Positions beyond the last register read as 0x00.
- R8: In a read, a master not-acknowledge (SDA high in the ninth clock) ends the transfer. SDA then stays released until the next start.
- R9: A register changes only as the result of an acknowledged data byte in a write.
- R10: The slave changes its SDA drive only while SCL is low, so SDA is stable through every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 8*NUM_REGS | Register contents, register k in bits [8k+7:8k] |

## Verification
The bench uses the defaults: four registers, device address 7'b1101001, and distinct default bytes per register. With four registers, a six-byte write runs past the end of the bank and a six-byte read crosses into the zero-filled region. The distinct defaults make a stray write to any register show up in `regs_o`. Random transfers of mixed lengths, stops after the placeholder bytes, repeated starts and wrong addresses are checked against a register model kept in the bench.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_RX,
    LS_RX_ACK,
    LS_TX,
    LS_TX_ACK
  } link_state_t;
endpackage

// File: rtl/ctlbus_sync.sv
module ctlbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic lvl_prev
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain    <= '1;
      lvl_prev <= 1'b1;
    end else begin
      chain    <= {chain[STAGES-2:0], din};
      lvl_prev <= chain[STAGES-1];
    end
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/ctlbus_regfile.sv
module ctlbus_regfile #(
  parameter int NUM_REGS = 4,
  parameter int PW = 3,
  parameter logic [8*NUM_REGS-1:0] REG_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [PW-1:0]         rd_addr,
  output logic [7:0]            rd_data,
  output logic [8*NUM_REGS-1:0] regs_q
);
  localparam logic [PW-1:0] LIMIT = PW'(NUM_REGS);

  always_ff @(posedge clk) begin
    if (rst) regs_q <= REG_INIT;
    else if (wr_en && (wr_addr < LIMIT)) regs_q[8*wr_addr +: 8] <= wr_data;
  end

  logic [7:0] rd_vec [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rd
    assign rd_vec[g] = regs_q[8*g +: 8];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == PW'(i)) rd_data = rd_vec[i];
  end

  // R6: the link never requests a write outside the bank
  p_write_in_bank_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr < LIMIT));
endmodule

// File: rtl/ctlbus_link.sv
module ctlbus_link
  import ctlbus_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int PW = 3,
  parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] rd_addr,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_low
);
  localparam logic [PW-1:0] LIMIT = PW'(NUM_REGS);

  link_state_t state;
  logic [3:0]    bitcnt;
  logic [2:0]    txcnt;
  logic [7:0]    shreg;
  logic [7:0]    txsh;
  logic [PW-1:0] ptr;
  logic [1:0]    dummy_left;
  logic          addr_phase;
  logic          rw;
  logic          ack_ok;

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state      <= LS_IDLE;
      sda_low    <= 1'b0;
      bitcnt     <= '0;
      txcnt      <= '0;
      shreg      <= '0;
      txsh       <= '0;
      ptr        <= '0;
      dummy_left <= '0;
      addr_phase <= 1'b0;
      rw         <= 1'b0;
      ack_ok     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else if (start_det) begin
      state      <= LS_RX;
      sda_low    <= 1'b0;
      bitcnt     <= '0;
      ptr        <= '0;
      dummy_left <= 2'd2;
      addr_phase <= 1'b1;
    end else if (stop_det) begin
      state   <= LS_IDLE;
      sda_low <= 1'b0;
    end else begin
      unique case (state)
        LS_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (addr_phase) begin
              if (shreg[7:1] == DEV_ADDR) begin
                rw      <= shreg[0];
                sda_low <= 1'b1;
                state   <= LS_RX_ACK;
              end else begin
                state <= LS_IDLE;
              end
            end else begin
              sda_low <= 1'b1;
              state   <= LS_RX_ACK;
              if (dummy_left != 2'd0) begin
                dummy_left <= dummy_left - 2'd1;
              end else if (ptr < LIMIT) begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
              end
            end
          end
        end
        LS_RX_ACK: begin
          if (scl_fall) begin
            addr_phase <= 1'b0;
            bitcnt     <= '0;
            if (addr_phase && rw) begin
              state   <= LS_TX;
              txsh    <= rd_data;
              txcnt   <= '0;
              sda_low <= ~rd_data[7];
            end else begin
              state   <= LS_RX;
              sda_low <= 1'b0;
            end
          end
        end
        LS_TX: begin
          if (scl_fall) begin
            if (txcnt == 3'd7) begin
              sda_low <= 1'b0;
              ack_ok  <= 1'b0;
              state   <= LS_TX_ACK;
            end else begin
              txsh    <= {txsh[6:0], 1'b0};
              sda_low <= ~txsh[6];
              txcnt   <= txcnt + 3'd1;
            end
          end
        end
        LS_TX_ACK: begin
          if (scl_rise) begin
            if (sda_lvl) begin
              state <= LS_IDLE;
            end else begin
              ack_ok <= 1'b1;
              if (ptr < LIMIT) ptr <= ptr + 1'b1;
            end
          end else if (scl_fall && ack_ok) begin
            state   <= LS_TX;
            txsh    <= rd_data;
            txcnt   <= '0;
            sda_low <= ~rd_data[7];
          end
        end
        default: begin
          sda_low <= 1'b0;
        end
      endcase
    end
  end

  // R2: a stop always leaves the line released
  p_release_after_stop_r2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_low);

  // R10: the drive is only asserted after SCL was seen low
  p_drive_only_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !$past(scl_lvl));

  // R8: an idle slave never pulls the line
  p_idle_released_r8: assert property (@(posedge clk) disable iff (rst)
    (state == LS_IDLE) |-> !sda_low);
endmodule

// File: rtl/ctlbus_regslave.sv
module ctlbus_regslave #(
  parameter int NUM_REGS = 4,
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter logic [8*NUM_REGS-1:0] REG_INIT = 32'h8E_F0_7F_FF,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_low,
  output logic [8*NUM_REGS-1:0] regs_o
);
  localparam int PW = $clog2(NUM_REGS + 1);

  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  ctlbus_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_i), .lvl(scl_s), .lvl_prev(scl_p));
  ctlbus_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_i), .lvl(sda_s), .lvl_prev(sda_p));

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  ctlbus_link #(.NUM_REGS(NUM_REGS), .PW(PW), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst(rst), .scl_lvl(scl_s), .sda_lvl(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_low(sda_drive_low));

  ctlbus_regfile #(.NUM_REGS(NUM_REGS), .PW(PW), .REG_INIT(REG_INIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_q(regs_o));

  // R9: the bank only moves the cycle after a write request
  p_regs_only_on_write_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(regs_o));
endmodule

// File: tb/ctlbus_regslave_bench.sv
module ctlbus_regslave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam logic [31:0] INIT = 32'h8E_F0_7F_FF;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_drive_low;
  logic [8*NR-1:0] regs_o;
  logic sda_bus;

  assign sda_bus = ~(m_low | sda_drive_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlbus_regslave u_ctlbus_regslave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .sda_drive_low(sda_drive_low), .regs_o(regs_o));

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  logic [7:0] model [NR];
  bit done = 0;

  function automatic logic [8*NR-1:0] packed_model();
    logic [8*NR-1:0] v;
    for (int k = 0; k < NR; k++) v[8*k +: 8] = model[k];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    m_low = 1'b1; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    m_low = 1'b0; wq(Q);
  endtask

  task automatic bit_write(input logic b);
    m_low = ~b; wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bit_read(output logic b);
    logic s1;
    m_low = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    s1 = sda_bus; wq(Q);
    b = sda_bus;
    if (s1 !== b) glitches++;
    scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_write(d[i]);
    bit_read(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_read(b);
      d[i] = b;
    end
    bit_write(~give_ack);
  endtask

  task automatic do_write(input int ndata);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a); chk("R3 write address ack", a, 1'b1);
    send_byte(8'($urandom), a); chk("R5 command byte ack", a, 1'b1);
    send_byte(8'($urandom), a); chk("R5 count byte ack", a, 1'b1);
    for (int k = 0; k < ndata; k++) begin
      d = 8'($urandom);
      send_byte(d, a);
      chk(k < NR ? "R5 data ack" : "R6 overflow ack", a, 1'b1);
      if (k < NR) model[k] = d;
    end
    bus_stop();
    chk("R5 R6 registers after write", regs_o, packed_model());
  endtask

  task automatic do_read(input int nbytes);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD3, a); chk("R3 read address ack", a, 1'b1);
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(k != nbytes - 1, d);
      chk(k < NR ? "R7 read register" : "R7 read beyond bank", d, k < NR ? model[k] : 8'h00);
    end
    recv_byte(1'b0, d);
    chk("R8 released after nack", d, 8'hFF);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    for (int k = 0; k < NR; k++) model[k] = INIT[8*k +: 8];
    void'($urandom(32'd2024));
    wq(5);
    chk("R1 defaults in reset", regs_o, INIT);
    chk("R1 sda released in reset", sda_drive_low, 1'b0);
    rst = 1'b0;
    wq(4);
    chk("R1 defaults after reset", regs_o, INIT);

    do_write(2);
    do_read(3);
    do_write(6);
    do_read(6);

    bus_start();
    send_byte(8'hA4, a); chk("R4 write mismatch nack", a, 1'b0);
    send_byte(8'hD2, a); chk("R4 ignored after mismatch", a, 1'b0);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    bus_stop();
    chk("R4 registers untouched", regs_o, packed_model());
    bus_start();
    send_byte(8'hA5, a); chk("R4 read mismatch nack", a, 1'b0);
    recv_byte(1'b0, d); chk("R4 no data on mismatch", d, 8'hFF);
    bus_stop();

    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    bus_stop();
    chk("R5 placeholders only", regs_o, packed_model());

    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'h3C, a); model[0] = 8'h3C;
    bus_stop();
    send_byte(8'h00, a); chk("R2 no ack after stop", a, 1'b0);
    chk("R2 registers after stop", regs_o, packed_model());

    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'hA7, a); model[0] = 8'hA7;
    bus_start();
    send_byte(8'hD3, a); chk("R2 repeated start ack", a, 1'b1);
    recv_byte(1'b0, d); chk("R2 read after repeated start", d, 8'hA7);
    bus_stop();

    for (int t = 0; t < 16; t++) begin
      if ($urandom % 2) do_write(int'($urandom % 7));
      else do_read(1 + int'($urandom % 6));
    end

    chk("R10 sda stable while scl high", glitches, 0);

    @(negedge clk); rst = 1'b1;
    wq(3);
    chk("R1 defaults after second reset", regs_o, INIT);
    rst = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule